// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It walks a two-level page table held in ordinary memory. A request carries the linear address, a write flag and the base of the top-level directory. The walker reads the directory entry selected by the top ten address bits. It then reads the page-table entry selected by the next ten bits. The low twelve bits pass through unchanged as the offset into a 4 KB page.

Each entry has a present flag, an accessed flag and a dirty flag. A clear present flag at either level stops the walk and reports a not-present fault, and the fault says which level failed. The walker sets the accessed flag in both entries before it reports success. On a write request it also sets the dirty flag in the page-table entry. It writes an entry back to memory only when one of these flags actually changes. It never touches the software-owned bits 11:9 or any other bit.

The memory side is a word-wide port. The walker holds each request until the memory raises ready. Read data is taken in the cycle that ready is high. Only one walk is in flight at a time, and each walk ends with a one-cycle done pulse or fault pulse.

Top module: `pageWalker`

## Requirements
- R1: After reset, reqReady is 1 and memReq, doneValid and faultValid are 0. A request is taken on a clock edge where reqValid and reqReady are both 1. reqReady then stays 0 until the cycle after the done or fault pulse.
- R2: The first memory access of a walk reads the directory entry at {dirBase[31:12], linAddr[31:22], 2'b00}. The low 12 bits of dirBase are ignored.
- R3: The page-table entry is read at {dirEntry[31:12], linAddr[21:12], 2'b00}.
- R4: A successful walk gives a one-cycle doneValid pulse in the cycle after the last memory handshake. During that pulse, physAddr = {tblEntry[31:12], linAddr[11:0]}.
- R5: If entry bit 0 (present) is 0 at either level, a one-cycle faultValid pulse follows in the cycle after that read. faultLevel is 0 for the directory and 1 for the table. The walk makes no further memory access.
- R6: If bit 5 (accessed) of the directory entry is 0, the entry is written back with bit 5 set. This write happens before the table entry is read.
- R7: The table entry is written back with bit 5 set when bit 5 is clear. On a write request it is also written back with bit 6 (dirty) set when bit 6 is clear. A read request never sets bit 6. This write happens before the done pulse.
- R8: No write-back is issued for an entry whose status bits would not change.
- R9: A write-back keeps every bit of the entry that was read, other than the status bits being set. This includes bits 11:9 and the upper 20 bits.
- R10: While memReq is 1 and memReady is 0, memReq, memAddr, memWrite and memWdata stay the same in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Translation request present |
| reqLinAddr | input | 32 | Linear address to translate |
| reqWrite | input | 1 | Request is for a write access |
| dirBase | input | 32 | Directory base; bits 11:0 ignored |
| reqReady | output | 1 | Walker idle and accepting a request |
| memReq | output | 1 | Memory access request |
| memWrite | output | 1 | Memory access is a write |
| memAddr | output | 32 | Memory word byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid while memReady is 1 |
| memReady | input | 1 | Memory completes the access this cycle |
| doneValid | output | 1 | One-cycle translation complete pulse |
| physAddr | output | 32 | Translated address, valid with doneValid |
| faultValid | output | 1 | One-cycle not-present fault pulse |
| faultLevel | output | 1 | Fault level: 0 directory, 1 table |

## Verification
A memory handshake completes on the edge where memReady is high. The walker's next state, next address or result pulse is visible one cycle after that edge. The bench drives memReady at the falling edge and checks the next handshake or the result pulse at the following falling edge. The done or fault pulse is expected in exactly the cycle after the last expected handshake, and its absence in any other cycle is checked. reqReady is compared on every cycle against a busy flag kept by the model. Memory latency varies from zero to two cycles, so the hold checks on the request lines are exercised.

// File: rtl/pageWalkerPkg.sv
package pageWalkerPkg;
  localparam int ADDR_W     = 32;
  localparam int ENTRY_W    = 32;
  localparam int OFFSET_W   = 12;
  localparam int IDX_W      = 10;
  localparam int WORD_SHIFT = 2;
  localparam int BASE_W     = ADDR_W - OFFSET_W;

  localparam int PRESENT_BIT  = 0;
  localparam int ACCESSED_BIT = 5;
  localparam int DIRTY_BIT    = 6;

  localparam logic [ENTRY_W-1:0] ACC_MASK   = ENTRY_W'(1) << ACCESSED_BIT;
  localparam logic [ENTRY_W-1:0] DIRTY_MASK = ENTRY_W'(1) << DIRTY_BIT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_DIR, ST_UPD_DIR, ST_READ_TBL, ST_UPD_TBL, ST_DONE, ST_FAULT
  } walkState_e;

  typedef struct packed {
    logic latchReq;
    logic capDir;
    logic capTbl;
    logic selTbl;
  } walkStrobe_t;

  typedef struct packed {
    logic present;
    logic needUpd;
  } entryStat_t;
endpackage

// File: rtl/walkCtrl.sv
module walkCtrl
  import pageWalkerPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReady,
  input  entryStat_t  stat,
  output walkStrobe_t strobe,
  output logic        reqReady,
  output logic        memReq,
  output logic        memWrite,
  output logic        doneValid,
  output logic        faultValid,
  output logic        faultLevel
);
  walkState_e state, nextState;
  logic levelReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      levelReg <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_READ_DIR && memReady) levelReg <= 1'b0;
      else if (state == ST_READ_TBL && memReady) levelReg <= 1'b1;
    end
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:     if (reqValid) nextState = ST_READ_DIR;
      ST_READ_DIR: if (memReady) begin
                     if (!stat.present)     nextState = ST_FAULT;
                     else if (stat.needUpd) nextState = ST_UPD_DIR;
                     else                   nextState = ST_READ_TBL;
                   end
      ST_UPD_DIR:  if (memReady) nextState = ST_READ_TBL;
      ST_READ_TBL: if (memReady) begin
                     if (!stat.present)     nextState = ST_FAULT;
                     else if (stat.needUpd) nextState = ST_UPD_TBL;
                     else                   nextState = ST_DONE;
                   end
      ST_UPD_TBL:  if (memReady) nextState = ST_DONE;
      ST_DONE:     nextState = ST_IDLE;
      ST_FAULT:    nextState = ST_IDLE;
      default:     nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.latchReq = (state == ST_IDLE) && reqValid;
    strobe.capDir   = (state == ST_READ_DIR) && memReady;
    strobe.capTbl   = (state == ST_READ_TBL) && memReady;
    strobe.selTbl   = (state == ST_READ_TBL) || (state == ST_UPD_TBL);
  end

  assign reqReady   = (state == ST_IDLE);
  assign memWrite   = (state == ST_UPD_DIR) || (state == ST_UPD_TBL);
  assign memReq     = memWrite || (state == ST_READ_DIR) || (state == ST_READ_TBL);
  assign doneValid  = (state == ST_DONE);
  assign faultValid = (state == ST_FAULT);
  assign faultLevel = levelReg;
endmodule

// File: rtl/walkDatapath.sv
module walkDatapath
  import pageWalkerPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobe_t        strobe,
  input  logic [ADDR_W-1:0]  reqLinAddr,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  dirBase,
  input  logic [ENTRY_W-1:0] memRdata,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [ENTRY_W-1:0] memWdata,
  output entryStat_t         stat,
  output logic [ADDR_W-1:0]  physAddr
);
  logic [ADDR_W-1:0]  linReg;
  logic               wrReg;
  logic [BASE_W-1:0]  dirBaseReg;
  logic [ENTRY_W-1:0] dirEntry, tblEntry;
  logic [IDX_W-1:0]   dirIdx, tblIdx;
  logic [ENTRY_W-1:0] dirMask, tblMask, curMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linReg     <= '0;
      wrReg      <= 1'b0;
      dirBaseReg <= '0;
      dirEntry   <= '0;
      tblEntry   <= '0;
    end else begin
      if (strobe.latchReq) begin
        linReg     <= reqLinAddr;
        wrReg      <= reqWrite;
        dirBaseReg <= dirBase[ADDR_W-1 -: BASE_W];
      end
      if (strobe.capDir) dirEntry <= memRdata;
      if (strobe.capTbl) tblEntry <= memRdata;
    end
  end

  assign dirIdx = linReg[ADDR_W-1 -: IDX_W];
  assign tblIdx = linReg[OFFSET_W +: IDX_W];

  // Status bits each level must carry once the walk passes it.
  assign dirMask = ACC_MASK;
  assign tblMask = ACC_MASK | (wrReg ? DIRTY_MASK : '0);
  assign curMask = strobe.selTbl ? tblMask : dirMask;

  assign memAddr  = strobe.selTbl
                  ? {dirEntry[ENTRY_W-1 -: BASE_W], tblIdx, {WORD_SHIFT{1'b0}}}
                  : {dirBaseReg, dirIdx, {WORD_SHIFT{1'b0}}};
  assign memWdata = strobe.selTbl ? (tblEntry | tblMask) : (dirEntry | dirMask);

  assign stat.present = memRdata[PRESENT_BIT];
  assign stat.needUpd = ((memRdata | curMask) != memRdata);

  assign physAddr = {tblEntry[ENTRY_W-1 -: BASE_W], linReg[OFFSET_W-1:0]};
endmodule

// File: rtl/pageWalker.sv
module pageWalker
  import pageWalkerPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqLinAddr,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  dirBase,
  output logic               reqReady,
  output logic               memReq,
  output logic               memWrite,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [ENTRY_W-1:0] memWdata,
  input  logic [ENTRY_W-1:0] memRdata,
  input  logic               memReady,
  output logic               doneValid,
  output logic [ADDR_W-1:0]  physAddr,
  output logic               faultValid,
  output logic               faultLevel
);
  walkStrobe_t strobe;
  entryStat_t  stat;

  walkCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memReady(memReady),
    .stat(stat), .strobe(strobe), .reqReady(reqReady), .memReq(memReq),
    .memWrite(memWrite), .doneValid(doneValid), .faultValid(faultValid),
    .faultLevel(faultLevel)
  );

  walkDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqLinAddr(reqLinAddr),
    .reqWrite(reqWrite), .dirBase(dirBase), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .stat(stat), .physAddr(physAddr)
  );
endmodule

// File: rtl/walkerChecker.sv
module walkerChecker
  import pageWalkerPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [ADDR_W-1:0]  reqLinAddr,
  input logic               reqReady,
  input logic               memReq,
  input logic               memWrite,
  input logic [ADDR_W-1:0]  memAddr,
  input logic [ENTRY_W-1:0] memWdata,
  input logic [ENTRY_W-1:0] memRdata,
  input logic               memReady,
  input logic               doneValid,
  input logic [ADDR_W-1:0]  physAddr,
  input logic               faultValid
);
  logic [ADDR_W-1:0]  acceptedLin;
  logic [ENTRY_W-1:0] lastRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptedLin <= '0;
      lastRead    <= '0;
    end else begin
      if (reqValid && reqReady) acceptedLin <= reqLinAddr;
      if (memReq && !memWrite && memReady) lastRead <= memRdata;
    end
  end

  assert_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  assert_offset_R4: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> physAddr[OFFSET_W-1:0] == acceptedLin[OFFSET_W-1:0]);

  assert_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWrite && memReady && !memRdata[PRESENT_BIT] |=> faultValid && !memReq);

  assert_setacc_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWrite |-> memWdata[ACCESSED_BIT]);

  assert_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWrite |->
      ((memWdata & ~(ACC_MASK | DIRTY_MASK)) == (lastRead & ~(ACC_MASK | DIRTY_MASK))));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWrite) && $stable(memWdata));
endmodule

bind pageWalker walkerChecker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLinAddr(reqLinAddr),
  .reqReady(reqReady), .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
  .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
  .doneValid(doneValid), .physAddr(physAddr), .faultValid(faultValid)
);

// File: tb/pageWalker_tb.sv
module pageWalker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqLinAddr = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] dirBase = 32'h0001_0ABC;
  logic        reqReady, memReq, memWrite, doneValid, faultValid, faultLevel;
  logic [31:0] memAddr, memWdata, physAddr;
  logic [31:0] memRdata = '0;
  logic        memReady = 1'b0;

  always #2 clk = ~clk;

  pageWalker u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLinAddr(reqLinAddr),
    .reqWrite(reqWrite), .dirBase(dirBase), .reqReady(reqReady), .memReq(memReq),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memReady(memReady), .doneValid(doneValid), .physAddr(physAddr),
    .faultValid(faultValid), .faultLevel(faultLevel)
  );

  typedef struct {
    logic [31:0] addr;
    logic        wr;
    logic [31:0] data;
    string       tag;
  } memOp_t;

  localparam int NSTIM = 9;
  logic [31:0] stimLin [NSTIM];
  bit          stimWr  [NSTIM];

  logic [31:0] mem [logic [31:0]];
  memOp_t opQ[$];
  int  errors = 0, checks = 0;
  int  stimIdx = 0, waitCnt = 0, grants = 0;
  bit  busy = 0, justDone = 0, pendingFinish = 0, finished = 0;
  bit  expFault = 0, expLevel = 0;
  logic [31:0] expPhys = '0;
  bit  holdValid = 0, holdWr = 0;
  logic [31:0] holdAddr = '0, holdData = '0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // Behavioural model: list the accesses a walk must make, from current memory.
  task automatic launchWalk(logic [31:0] lin, bit wr);
    logic [31:0] dAddr, dEnt, tAddr, tEnt, tNew;
    bit skippedDir;
    memOp_t op;
    dAddr = {dirBase[31:12], lin[31:22], 2'b00};
    dEnt = rd(dAddr);
    op.addr = dAddr; op.wr = 0; op.data = 0; op.tag = "R2"; opQ.push_back(op);
    if (!dEnt[0]) begin expFault = 1; expLevel = 0; return; end
    skippedDir = dEnt[5];
    if (!dEnt[5]) begin
      op.addr = dAddr; op.wr = 1; op.data = dEnt | 32'h20; op.tag = "R6 R9"; opQ.push_back(op);
    end
    tAddr = {dEnt[31:12], lin[21:12], 2'b00};
    tEnt = rd(tAddr);
    op.addr = tAddr; op.wr = 0; op.data = 0;
    op.tag = skippedDir ? "R3 R8" : "R3"; opQ.push_back(op);
    if (!tEnt[0]) begin expFault = 1; expLevel = 1; return; end
    tNew = tEnt | 32'h20 | (wr ? 32'h40 : 32'h0);
    if (tNew != tEnt) begin
      op.addr = tAddr; op.wr = 1; op.data = tNew; op.tag = "R7 R9"; opQ.push_back(op);
    end
    expFault = 0;
    expPhys = {tEnt[31:12], lin[11:0]};
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(reqReady == !busy, "R1", "reqReady", {31'b0, reqReady}, {31'b0, !busy});
      reqValid = 1'b0;
      memReady = 1'b0;

      check((doneValid || faultValid) == pendingFinish, expFault ? "R5" : "R4",
            "result pulse timing", {30'b0, doneValid, faultValid}, {31'b0, pendingFinish});
      if (doneValid) begin
        check(!expFault, "R4", "done instead of fault", 32'd1, 32'd0);
        check(physAddr == expPhys, "R4", "physAddr", physAddr, expPhys);
      end
      if (faultValid) begin
        check(expFault, "R5", "fault instead of done", 32'd1, 32'd0);
        check(faultLevel == expLevel, "R5", "faultLevel", {31'b0, faultLevel}, {31'b0, expLevel});
      end
      if (pendingFinish || doneValid || faultValid) begin busy = 0; justDone = 1; end
      pendingFinish = 0;

      if (holdValid) begin
        check(memReq && memAddr == holdAddr && memWrite == holdWr && (!holdWr || memWdata == holdData),
              "R10", "request held while waiting", memAddr, holdAddr);
        holdValid = 0;
      end
      if (memReq) begin
        if (waitCnt > 0) begin
          waitCnt--;
          holdValid = 1; holdAddr = memAddr; holdWr = memWrite; holdData = memWdata;
        end else begin
          if (opQ.size() == 0) begin
            check(0, "R8", "unexpected memory access", memAddr, 32'h0);
          end else begin
            memOp_t op;
            op = opQ.pop_front();
            check(memWrite == op.wr, op.tag, "access kind", {31'b0, memWrite}, {31'b0, op.wr});
            check(memAddr == op.addr, op.tag, "access address", memAddr, op.addr);
            if (op.wr && memWrite)
              check(memWdata == op.data, op.tag, "write-back data", memWdata, op.data);
            if (opQ.size() == 0) pendingFinish = 1;
          end
          if (memWrite) mem[memAddr] = memWdata;
          else memRdata = rd(memAddr);
          memReady = 1'b1;
          grants++;
          waitCnt = grants % 3;
        end
      end

      if (!busy && !justDone && stimIdx < NSTIM) begin
        reqLinAddr = stimLin[stimIdx];
        reqWrite = stimWr[stimIdx];
        launchWalk(stimLin[stimIdx], stimWr[stimIdx]);
        reqValid = 1'b1;
        busy = 1;
        stimIdx++;
      end
      justDone = 0;
    end
  end

  initial begin
    // Directory at 0x10000; the low bits of dirBase must be ignored (R2).
    mem[32'h0001_0004] = 32'h0002_0E01;  // dir 1: present, accessed clear, bits 11:9 set
    mem[32'h0001_0008] = 32'h0003_0E20;  // dir 2: not present
    mem[32'h0001_0FFC] = 32'h0004_0063;  // dir 1023: present, accessed and dirty set
    mem[32'h0002_000C] = 32'h1234_5C01;  // table idx 3: accessed clear
    mem[32'h0002_0010] = 32'h0055_5E20;  // table idx 4: not present
    mem[32'h0002_0014] = 32'hABCD_E221;  // table idx 5: accessed set, dirty clear
    mem[32'h0002_0018] = 32'h7777_7001;  // table idx 6: accessed clear
    mem[32'h0004_0FFC] = 32'hFEDC_BE61;  // table idx 1023: all status set
    stimLin[0] = 32'h0040_3123; stimWr[0] = 0;  // R6 R7 both write-backs
    stimLin[1] = 32'h0040_3123; stimWr[1] = 0;  // R8 no write-back
    stimLin[2] = 32'h0040_3123; stimWr[2] = 1;  // R7 dirty set on write
    stimLin[3] = 32'h0040_3123; stimWr[3] = 1;  // R8 nothing changes
    stimLin[4] = 32'h0080_0456; stimWr[4] = 1;  // R5 directory fault
    stimLin[5] = 32'h0040_4789; stimWr[5] = 1;  // R5 table fault
    stimLin[6] = 32'h0040_5FFF; stimWr[6] = 1;  // R7 dirty only
    stimLin[7] = 32'h0040_6000; stimWr[7] = 0;  // R7 read leaves dirty clear
    stimLin[8] = 32'hFFFF_F00F; stimWr[8] = 1;  // R3 R4 top indices, no write-back

    repeat (3) @(negedge clk);
    check(reqReady && !memReq && !doneValid && !faultValid, "R1", "reset state",
          {28'b0, reqReady, memReq, doneValid, faultValid}, 32'h8);
    @(posedge clk);
    #1 rstN = 1'b1;
    wait (stimIdx == NSTIM && !busy);
    repeat (5) @(negedge clk);
    check(opQ.size() == 0, "R8", "accesses left outstanding", opQ.size(), 32'h0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual busy %0d expected idle 0", busy);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule